// File: doc/BRIEF.md
# Banked Asynchronous Memory Bus Controller

This block turns one internal memory request at a time into a strobed transaction on an external asynchronous memory bus shared by four banks. The requester presents a byte address, a bank number, a read/write flag, write data and two byte enables, then raises a request. The controller walks the selected bank through a setup phase, a strobe phase and a hold phase, and pulses an acknowledge when the transaction is over. For reads, the assembled data is returned with that acknowledge.

Each bank has its own configuration, given on static input vectors. The configuration sets the bus width (8 or 16 bits), whether the wait input is honoured, and the length of each phase (1 to 15 cycles). The whole configuration of the addressed bank is latched when a request is accepted. A 16-bit request to an 8-bit bank is split into two byte beats, low byte first. On an 8-bit bank the upper byte strobe carries address bit 0, and the upper data lanes are never driven. The data bus is presented as a separate output word, an input word and one output-enable per byte lane.

The state machine has five states:
- IDLE: accepts a request and goes to SETUP.
- SETUP: after the configured number of cycles, goes to STROBE.
- STROBE: stalls while an enabled wait input is high at its midpoint cycle. After the configured number of cycles, it goes to HOLD and captures read data.
- HOLD: at its end, goes back to SETUP if a second byte beat is pending, otherwise to DONE.
- DONE: raises acknowledge for one cycle and returns to IDLE.

Requests are accepted only in IDLE.

Top module: `xbus_ctrl`

## Requirements
- R1: During and straight after reset, `ack_o` is 0, all `ce_n_o` and `oe_n_o` bits are 1, `bs_n_o` is 2'b11 and `dq_oe_o` is 0.
- R2: `ext_addr_o` equals internal address bits 19..1, ignoring bits 29..20 and bit 0, and stays constant while any chip enable is low.
- R3: Only the addressed bank's `ce_n_o` bit is low, for every cycle of setup, strobe and hold of every beat. Its `oe_n_o` bit is low only on reads and only in strobe cycles, so on a read the count of `oe_n_o` low cycles equals the count of strobe cycles.
- R4: With setup S, strobe T and hold H cycles, wait stall cycles X per beat, and B beats, `ack_o` is high in cycle B*(S+T+H+X)+1 after the accepting edge.
- R5: `ack_o` is high for exactly one cycle. A request held high while busy starts no new transaction.
- R6: On a write to a 16-bit bank, `dq_oe_o` is 2'b11 and `dq_out_o` equals the write data for the whole access. `bs_n_o[i]` is low in strobe cycles exactly when byte enable i is 1.
- R7: On an 8-bit bank, `dq_oe_o[1]` is 0 throughout the access. On a write, `dq_oe_o[0]` is 1, the byte goes out on lines 7..0, `bs_n_o[0]` strobes it, and `bs_n_o[1]` carries address bit 0.
- R8: On an 8-bit bank, byte enables 2'b11 give two beats, lane 0 (A0=0) first and then lane 1 (A0=1). Byte enables 2'b01 or 2'b10 give a single beat with A0 equal to the lane number.
- R9: A read from a 16-bit bank returns all 16 input lines as sampled in the last strobe cycle, whatever the byte enables. Data lines are not driven during reads.
- R10: A read from an 8-bit bank returns each enabled byte, taken from input lines 7..0, in the lane given by A0. Lanes that are not enabled read 0, and input lines 15..8 are ignored.
- R11: With wait enabled, the wait input is sampled only in strobe cycle ceil(T/2). Each high sample there holds the strobe one more cycle. A high level in any other cycle adds nothing.
- R12: With wait disabled for the bank, the wait input has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request, sampled in IDLE |
| addr_i | input | 30 | Internal byte address |
| bank_i | input | 2 | Bank number |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables, bit i for bits 8i+7..8i |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with ack |
| cfg_narrow_i | input | 4 | Per bank: 1 = 8-bit bus |
| cfg_wait_en_i | input | 4 | Per bank: honour wait input |
| cfg_setup_i | input | 16 | Per bank 4-bit setup length, bank b at bits 4b+3..4b |
| cfg_strobe_i | input | 16 | Per bank 4-bit strobe length |
| cfg_hold_i | input | 16 | Per bank 4-bit hold length |
| ext_addr_o | output | 19 | External address, bits 19..1 |
| dq_out_o | output | 16 | Data lines driven value |
| dq_oe_o | output | 2 | Drive enable per byte lane |
| dq_in_i | input | 16 | Data lines sampled value |
| ce_n_o | output | 4 | Active-low chip enables |
| oe_n_o | output | 4 | Active-low output enables |
| bs_n_o | output | 2 | Active-low byte strobes (bit 1 = A0 on 8-bit banks) |
| wait_i | input | 1 | External wait |

## Verification
The bench targets the wait midpoint with a one-cycle pulse just before it. A design sampling wait too early, or on every strobe cycle, shows extra latency. Splitting on 8-bit banks is checked with byte enables 2'b11, 2'b01 and 2'b10: a design with the beat order reversed or the A0 line wrong writes bytes to the wrong lanes or puts read bytes in the wrong place. Noise on the upper input lines during 8-bit reads catches a design that lets them through. Disabled wait is checked with the same wait pattern applied, and high address bits are randomised so that a design leaking them shows address errors.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int XB_NBANK = 4;
    localparam int XB_PHW   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } xb_state_e;

    typedef struct packed {
        logic              narrow;
        logic              wait_en;
        logic [XB_PHW-1:0] setup;
        logic [XB_PHW-1:0] strobe;
        logic [XB_PHW-1:0] hold;
    } xb_bank_cfg_t;
endpackage

// File: rtl/xbus_cfg_sel.sv
module xbus_cfg_sel
    import xbus_pkg::*;
#(
    parameter int NB = XB_NBANK,
    parameter int BW = $clog2(NB)
) (
    input  logic [NB-1:0]        narrow_i,
    input  logic [NB-1:0]        wait_en_i,
    input  logic [NB*XB_PHW-1:0] setup_i,
    input  logic [NB*XB_PHW-1:0] strobe_i,
    input  logic [NB*XB_PHW-1:0] hold_i,
    input  logic [BW-1:0]        sel_i,
    output xb_bank_cfg_t         cfg_o
);
    xb_bank_cfg_t tbl [NB];

    for (genvar g = 0; g < NB; g++) begin : g_bank
        assign tbl[g].narrow  = narrow_i[g];
        assign tbl[g].wait_en = wait_en_i[g];
        assign tbl[g].setup   = setup_i[g*XB_PHW +: XB_PHW];
        assign tbl[g].strobe  = strobe_i[g*XB_PHW +: XB_PHW];
        assign tbl[g].hold    = hold_i[g*XB_PHW +: XB_PHW];
    end

    assign cfg_o = tbl[sel_i];
endmodule

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         adv_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= W'(1);
        end else if (adv_i) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane #(
    parameter int DW = 16
) (
    input  logic          narrow_i,
    input  logic          lane_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] dq_in_i,
    input  logic [DW-1:0] rd_prev_i,
    output logic [DW-1:0] dq_out_o,
    output logic [DW-1:0] rd_merge_o
);
    localparam int BYTE = 8;

    always_comb begin
        if (narrow_i) begin
            dq_out_o = {{(DW-BYTE){1'b0}},
                        (lane_i ? wdata_i[DW-1 -: BYTE] : wdata_i[BYTE-1:0])};
            if (lane_i) begin
                rd_merge_o = {dq_in_i[BYTE-1:0], rd_prev_i[BYTE-1:0]};
            end else begin
                rd_merge_o = {rd_prev_i[DW-1:BYTE], dq_in_i[BYTE-1:0]};
            end
        end else begin
            dq_out_o   = wdata_i;
            rd_merge_o = dq_in_i;
        end
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int NB  = XB_NBANK,
    parameter int BW  = $clog2(NB),
    parameter int AW  = 30,
    parameter int EAW = 19,
    parameter int DW  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [BW-1:0]        bank_i,
    input  logic                 wr_i,
    input  logic [DW-1:0]        wdata_i,
    input  logic [1:0]           be_i,
    output logic                 ack_o,
    output logic [DW-1:0]        rdata_o,
    input  logic [NB-1:0]        cfg_narrow_i,
    input  logic [NB-1:0]        cfg_wait_en_i,
    input  logic [NB*XB_PHW-1:0] cfg_setup_i,
    input  logic [NB*XB_PHW-1:0] cfg_strobe_i,
    input  logic [NB*XB_PHW-1:0] cfg_hold_i,
    output logic [EAW-1:0]       ext_addr_o,
    output logic [DW-1:0]        dq_out_o,
    output logic [1:0]           dq_oe_o,
    input  logic [DW-1:0]        dq_in_i,
    output logic [NB-1:0]        ce_n_o,
    output logic [NB-1:0]        oe_n_o,
    output logic [1:0]           bs_n_o,
    input  logic                 wait_i
);
    localparam logic [NB-1:0] ONE_BANK = {{(NB-1){1'b0}}, 1'b1};

    xb_state_e      state_q, state_d;
    xb_bank_cfg_t   cfg_sel, cfg_q;
    logic [BW-1:0]  bank_q;
    logic           wr_q;
    logic [1:0]     be_q;
    logic [DW-1:0]  wdata_q;
    logic [EAW-1:0] addr_q;
    logic           lane_q;
    logic           more_q;
    logic [DW-1:0]  rdata_q;

    logic [XB_PHW-1:0] cnt;
    logic [XB_PHW:0]   mid_w;
    logic              ctr_start, ctr_adv;
    logic              accept, stall, strobe_end, beat_next;
    logic [DW-1:0]     lane_out, rd_merge;
    logic              cur_narrow;
    logic              busy;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{addr_i[AW-1:EAW+1], addr_i[0]};
    assign cur_narrow       = cfg_q.narrow;
    assign mid_w            = ({1'b0, cfg_q.strobe} + 1'b1) >> 1;

    xbus_cfg_sel #(.NB(NB), .BW(BW)) u_cfg (
        .narrow_i (cfg_narrow_i),
        .wait_en_i(cfg_wait_en_i),
        .setup_i  (cfg_setup_i),
        .strobe_i (cfg_strobe_i),
        .hold_i   (cfg_hold_i),
        .sel_i    (bank_i),
        .cfg_o    (cfg_sel)
    );

    xbus_phase_ctr #(.W(XB_PHW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(ctr_start),
        .adv_i  (ctr_adv),
        .cnt_o  (cnt)
    );

    xbus_lane #(.DW(DW)) u_lane (
        .narrow_i  (cur_narrow),
        .lane_i    (lane_q),
        .wdata_i   (wdata_q),
        .dq_in_i   (dq_in_i),
        .rd_prev_i (rdata_q),
        .dq_out_o  (lane_out),
        .rd_merge_o(rd_merge)
    );

    // Next state and phase counter control
    always_comb begin
        state_d    = state_q;
        ctr_start  = 1'b0;
        ctr_adv    = 1'b0;
        accept     = 1'b0;
        stall      = 1'b0;
        strobe_end = 1'b0;
        beat_next  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    accept    = 1'b1;
                    ctr_start = 1'b1;
                    state_d   = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (cnt == cfg_q.setup) begin
                    ctr_start = 1'b1;
                    state_d   = ST_STROBE;
                end else begin
                    ctr_adv = 1'b1;
                end
            end
            ST_STROBE: begin
                stall = cfg_q.wait_en && wait_i && (cnt == mid_w[XB_PHW-1:0]);
                if (!stall) begin
                    if (cnt == cfg_q.strobe) begin
                        ctr_start  = 1'b1;
                        strobe_end = 1'b1;
                        state_d    = ST_HOLD;
                    end else begin
                        ctr_adv = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt == cfg_q.hold) begin
                    ctr_start = 1'b1;
                    beat_next = more_q;
                    state_d   = more_q ? ST_SETUP : ST_DONE;
                end else begin
                    ctr_adv = 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register and transaction datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            bank_q  <= '0;
            wr_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
            addr_q  <= '0;
            lane_q  <= 1'b0;
            more_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cfg_q   <= cfg_sel;
                bank_q  <= bank_i;
                wr_q    <= wr_i;
                be_q    <= be_i;
                wdata_q <= wdata_i;
                addr_q  <= addr_i[EAW:1];
                lane_q  <= cfg_sel.narrow && (be_i == 2'b10);
                more_q  <= cfg_sel.narrow && (be_i == 2'b11);
                rdata_q <= '0;
            end
            if (strobe_end && !wr_q) begin
                rdata_q <= rd_merge;
            end
            if (beat_next) begin
                lane_q <= 1'b1;
                more_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        logic strobing;
        busy     = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        strobing = (state_q == ST_STROBE);
        ce_n_o   = busy ? ~(ONE_BANK << bank_q) : '1;
        oe_n_o   = (strobing && !wr_q) ? ~(ONE_BANK << bank_q) : '1;
        if (cur_narrow) begin
            bs_n_o[0] = !(strobing && be_q[lane_q]);
            bs_n_o[1] = lane_q;
            dq_oe_o   = (busy && wr_q) ? 2'b01 : 2'b00;
        end else begin
            bs_n_o[0] = !(strobing && be_q[0]);
            bs_n_o[1] = !(strobing && be_q[1]);
            dq_oe_o   = (busy && wr_q) ? 2'b11 : 2'b00;
        end
        dq_out_o   = lane_out;
        ext_addr_o = addr_q;
        ack_o      = (state_q == ST_DONE);
        rdata_o    = rdata_q;
    end
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk #(
    parameter int NB  = 4,
    parameter int EAW = 19
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ack,
    input logic [NB-1:0]  ce_n,
    input logic [NB-1:0]  oe_n,
    input logic [1:0]     dq_oe,
    input logic [EAW-1:0] ext_addr,
    input logic           narrow
);
    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R3
    single_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ce_n) <= 1);

    // R3
    oe_within_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~oe_n & ce_n) == '0);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n != '1 && $past(ce_n) != '1) |-> $stable(ext_addr));

    // R7
    narrow_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow && ce_n != '1) |-> !dq_oe[1]);

    // R9
    read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n != '1) |-> (dq_oe == 2'b00));

    // R4
    ack_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (ce_n == '1));
endmodule

bind xbus_ctrl xbus_chk #(.NB(NB), .EAW(EAW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ack_o),
    .ce_n    (ce_n_o),
    .oe_n    (oe_n_o),
    .dq_oe   (dq_oe_o),
    .ext_addr(ext_addr_o),
    .narrow  (cur_narrow)
);

// File: tb/sim_xbus_ctrl.sv
module sim_xbus_ctrl;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        req;
    logic [29:0] addr;
    logic [1:0]  bank;
    logic        wr;
    logic [15:0] wdata;
    logic [1:0]  be;
    logic        ack;
    logic [15:0] rdata;
    logic [3:0]  cfg_narrow, cfg_wen;
    logic [15:0] cfg_setup, cfg_strobe, cfg_hold;
    logic [18:0] ext_addr;
    logic [15:0] dq_out, dq_in;
    logic [1:0]  dq_oe, bs_n;
    logic [3:0]  ce_n, oe_n;
    logic        ext_wait;

    int su [4];
    int st [4];
    int ho [4];
    int total = 0;
    int bad   = 0;

    xbus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .bank_i(bank),
        .wr_i(wr), .wdata_i(wdata), .be_i(be), .ack_o(ack), .rdata_o(rdata),
        .cfg_narrow_i(cfg_narrow), .cfg_wait_en_i(cfg_wen),
        .cfg_setup_i(cfg_setup), .cfg_strobe_i(cfg_strobe), .cfg_hold_i(cfg_hold),
        .ext_addr_o(ext_addr), .dq_out_o(dq_out), .dq_oe_o(dq_oe), .dq_in_i(dq_in),
        .ce_n_o(ce_n), .oe_n_o(oe_n), .bs_n_o(bs_n), .wait_i(ext_wait)
    );

    function automatic logic [7:0] mem_byte(int b, logic [18:0] a, logic a0);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ {a0, 2'(b), 5'h13};
    endfunction

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            cfg_setup[b*4 +: 4]  = 4'(su[b]);
            cfg_strobe[b*4 +: 4] = 4'(st[b]);
            cfg_hold[b*4 +: 4]   = 4'(ho[b]);
        end
    end

    // External memory model: noise unless an output enable is low
    always_comb begin
        dq_in = 16'hC3C3;
        for (int b = 0; b < 4; b++) begin
            if (!oe_n[b]) begin
                if (cfg_narrow[b]) dq_in = {8'hEE, mem_byte(b, ext_addr, bs_n[1])};
                else dq_in = {mem_byte(b, ext_addr, 1'b1), mem_byte(b, ext_addr, 1'b0)};
            end
        end
    end

    task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic set_bank(int b, bit nar, bit wen, int s, int t, int h);
        cfg_narrow[b] = nar;
        cfg_wen[b]    = wen;
        su[b] = s; st[b] = t; ho[b] = h;
    endtask

    task automatic txn(int b, bit w, logic [29:0] a, logic [1:0] e, logic [15:0] d,
                       int wt, bit early);
        bit   nar = cfg_narrow[b];
        bit   wen = cfg_wen[b];
        int   mid = (st[b] + 1) / 2;
        int   beats = (nar && e == 2'b11) ? 2 : 1;
        int   exp_cyc = beats * (su[b] + st[b] + ho[b] + (wen ? wt : 0)) + 1;
        int   n = 0, j = 0, oe_cnt = 0, nbeat = 0;
        int   e_ce = 0, e_addr = 0, e_lane = 0, e_oe = 0, e_drv = 0;
        bit   prev_vis = 0, vis;
        logic [1:0]  seen = 0;
        logic [15:0] wb = 0;
        int   first_a0 = -1;
        logic [15:0] exp_rd;

        @(negedge clk);
        chk(ack == 1'b0, "R5", 32'(ack), 0);
        req = 1'b1; bank = 2'(b); wr = w; addr = a; be = e; wdata = d;
        forever begin
            @(negedge clk);
            n++;
            vis = !oe_n[b] || !bs_n[0] || (!nar && !bs_n[1]);
            j = vis ? j + 1 : 0;
            if (vis && !prev_vis) nbeat++;
            prev_vis = vis;
            ext_wait = (j > 0) && ((j >= mid && j < mid + wt) ||
                                   (early && mid > 1 && j == mid - 1));
            if (!oe_n[b]) oe_cnt++;
            if (ce_n != 4'hF) begin
                if (ce_n != ~(4'b1 << b)) e_ce++;
                if (ext_addr != a[19:1]) e_addr++;
                if (w && oe_n != 4'hF) e_oe++;
                if (nar) begin
                    if (dq_oe[1]) e_lane++;
                    if (dq_oe[0] != w) e_drv++;
                    if (w && !bs_n[0]) begin
                        seen[bs_n[1]] = 1'b1;
                        if (bs_n[1]) wb[15:8] = dq_out[7:0]; else wb[7:0] = dq_out[7:0];
                        if (first_a0 < 0) first_a0 = int'(bs_n[1]);
                    end else if (!w && !oe_n[b] && first_a0 < 0) begin
                        first_a0 = int'(bs_n[1]);
                    end
                end else begin
                    if (dq_oe != (w ? 2'b11 : 2'b00)) e_drv++;
                    if (w && dq_out != d) e_drv++;
                    if (w && !bs_n[0]) begin seen[0] = 1'b1; wb[7:0]  = dq_out[7:0];  end
                    if (w && !bs_n[1]) begin seen[1] = 1'b1; wb[15:8] = dq_out[15:8]; end
                end
            end
            if (ack || n > 3000) break;
        end
        req = 1'b0; ext_wait = 1'b0;

        if (n > 3000) chk(0, "R4 watchdog", 32'(n), 32'(exp_cyc));
        if (wen) chk(n == exp_cyc, "R4 R11 latency", 32'(n), 32'(exp_cyc));
        else     chk(n == exp_cyc, "R4 R12 latency", 32'(n), 32'(exp_cyc));
        chk(e_ce == 0, "R3 chip enable", 32'(e_ce), 0);
        chk(e_addr == 0, "R2 address", 32'(e_addr), 0);
        chk(oe_cnt == (w ? 0 : beats * (st[b] + (wen ? wt : 0))), "R3 output enable",
            32'(oe_cnt), 32'(w ? 0 : beats * (st[b] + (wen ? wt : 0))));
        chk(e_oe == 0, "R3 oe on write", 32'(e_oe), 0);
        chk(nbeat == beats, "R8 beat count", 32'(nbeat), 32'(beats));
        if (nar) begin
            chk(e_lane == 0, "R7 upper lanes float", 32'(e_lane), 0);
            chk(e_drv == 0, "R7 lane drive", 32'(e_drv), 0);
            chk(first_a0 == ((e == 2'b10) ? 1 : 0), "R8 first A0", 32'(first_a0),
                32'((e == 2'b10) ? 1 : 0));
        end else begin
            chk(e_drv == 0, "R6 drive", 32'(e_drv), 0);
        end
        if (w) begin
            chk(seen == e, nar ? "R7 byte strobes" : "R6 byte strobes", 32'(seen), 32'(e));
            chk((wb & {{8{e[1]}}, {8{e[0]}}}) == (d & {{8{e[1]}}, {8{e[0]}}}),
                nar ? "R7 write bytes" : "R6 write data", 32'(wb), 32'(d));
        end else begin
            if (nar) begin
                exp_rd = {(e[1] ? mem_byte(b, a[19:1], 1'b1) : 8'h00),
                          (e[0] ? mem_byte(b, a[19:1], 1'b0) : 8'h00)};
                chk(rdata == exp_rd, "R10 narrow read", 32'(rdata), 32'(exp_rd));
            end else begin
                exp_rd = {mem_byte(b, a[19:1], 1'b1), mem_byte(b, a[19:1], 1'b0)};
                chk(rdata == exp_rd, "R9 wide read", 32'(rdata), 32'(exp_rd));
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        chk(0, "R4 global watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req = 0; addr = 0; bank = 0; wr = 0; wdata = 0; be = 0;
        ext_wait = 0; cfg_narrow = 0; cfg_wen = 0;
        for (int b = 0; b < 4; b++) set_bank(b, 0, 0, 1, 1, 1);
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(ack == 0 && ce_n == 4'hF && oe_n == 4'hF && bs_n == 2'b11 && dq_oe == 0,
            "R1 reset", {ack, ce_n, oe_n, bs_n, dq_oe}, {1'b0, 4'hF, 4'hF, 2'b11, 2'b00});
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack == 0 && ce_n == 4'hF && oe_n == 4'hF && bs_n == 2'b11 && dq_oe == 0,
            "R1 after reset", {ack, ce_n, oe_n, bs_n, dq_oe}, {1'b0, 4'hF, 4'hF, 2'b11, 2'b00});

        // Directed: wide bank
        set_bank(0, 0, 0, 2, 3, 1);
        txn(0, 1, 30'h3FF0_1234, 2'b11, 16'hA55A, 0, 0);
        txn(0, 1, 30'h0000_2002, 2'b01, 16'h1234, 0, 0);
        txn(0, 0, 30'h2AA5_5556, 2'b10, 16'h0, 0, 0);
        // Directed: narrow bank, split and single beats
        set_bank(1, 1, 0, 1, 2, 2);
        txn(1, 1, 30'h1000_0ABC, 2'b11, 16'hBEEF, 0, 0);
        txn(1, 1, 30'h0000_0ABC, 2'b10, 16'hC0DE, 0, 0);
        txn(1, 0, 30'h3000_7770, 2'b11, 16'h0, 0, 0);
        txn(1, 0, 30'h0004_0000, 2'b01, 16'h0, 0, 0);
        txn(1, 0, 30'h0004_0000, 2'b10, 16'h0, 0, 0);
        // Directed: wait midpoint, early pulse, disabled wait
        set_bank(2, 0, 1, 1, 5, 1);
        txn(2, 0, 30'h0001_1110, 2'b11, 16'h0, 3, 1);
        txn(2, 1, 30'h0001_1110, 2'b11, 16'h7777, 0, 1);
        set_bank(3, 1, 1, 1, 1, 1);
        txn(3, 0, 30'h0002_2220, 2'b11, 16'h0, 2, 0);
        set_bank(3, 1, 0, 1, 4, 1);
        txn(3, 0, 30'h0002_2220, 2'b11, 16'h0, 3, 1);
        // Directed: longest phases
        set_bank(0, 0, 1, 15, 15, 15);
        txn(0, 1, 30'h3FFF_FFFE, 2'b11, 16'hFFFF, 2, 1);

        // Random mix
        for (int i = 0; i < 150; i++) begin
            int  b = int'($urandom_range(3, 0));
            int  s = ($urandom_range(15, 0) == 0) ? 15 : int'($urandom_range(4, 1));
            int  t = ($urandom_range(15, 0) == 0) ? 15 : int'($urandom_range(4, 1));
            int  h = int'($urandom_range(4, 1));
            logic [1:0] e = 2'($urandom_range(3, 1));
            set_bank(b, 1'($urandom), 1'($urandom), s, t, h);
            txn(b, 1'($urandom), 30'($urandom), e, 16'($urandom),
                int'($urandom_range(3, 0)), 1'($urandom));
        end

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule